// File: doc/BRIEF.md
# Translation Fault Record Register

This block sits beside an address-translation walker and keeps a record of the first translation fault that the walker reports. When reporting is enabled and no record is held, a fault pulse is packed into one 64-bit status word. The word holds the fault class, the requester ID and the low 32 bits of the faulting device address. A level interrupt then stays high until software releases the record.

Software reaches the block through a small register port. Writes take effect on the next clock edge and reads are combinational. The port exposes three words: the status word, a control word with a reporting enable and a 10-bit parameter field, and a saturating count of faults that arrived while a record was already held. Such faults are counted and dropped.

To release the record, software writes the status word back with bit 62 cleared. The fault-type encodings are 0 to 3 for a missing table entry (device table level 1, device table level 2, page table level 1, page table level 2), 4 for an access that is not permitted and 5 for an illegal completion.

Top module: `iommu_fault_recorder`

## Requirements
- R1: After reset, the status, control and overflow words all read 0 and `irq_o` is low.
- R2: A fault pulse is captured when control bit 63 is 1 and status bit 63 is 0. On the next edge, the status word takes bits 63 and 62 = 1, type in 61:59, requester ID in 52:37, address in 31:0, and 0 in every other bit.
- R3: While control bit 63 is 0, a fault pulse changes neither the status word nor the overflow count.
- R4: While status bit 63 is 1, an enabled fault pulse leaves the status word unchanged and raises the overflow count (word index 2, bits 7:0) by one.
- R5: The overflow count saturates at 255.
- R6: Writing the status word (index 0) with bit 62 = 0 clears status bits 63 and 62 on the next edge and keeps the other fields. `irq_o` falls with bit 63.
- R7: Writing the status word with bit 62 = 1 has no effect.
- R8: The control word (index 1) stores only bit 63 (enable) and bits 19:10 (parameter field). All other bits read 0.
- R9: An enabled fault in the same cycle as a releasing write is resolved as follows. If a record is held, the fault is counted and the record is released. If no record is held, the fault is captured.
- R10: `irq_o` is high exactly while status bit 63 is 1. A fault that arrives after a release is captured as a fresh record.
- R11: Writes to word index 2 or 3 are ignored, and index 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fault_valid_i | input | 1 | One-cycle fault report from the walker |
| fault_type_i | input | 3 | Fault class |
| fault_rid_i | input | 16 | Requester ID of the faulting access |
| fault_addr_i | input | 32 | Faulting device address |
| wr_en_i | input | 1 | Register write strobe |
| reg_idx_i | input | 2 | Word index: 0 status, 1 control, 2 overflow |
| wdata_i | input | 64 | Write data |
| rdata_o | output | 64 | Read data for `reg_idx_i` |
| irq_o | output | 1 | Level fault interrupt |

## Verification
The bench goes after the cases where the record must be held.

- A second fault during a held record must not overwrite the first record. A design that overwrote it would report the wrong requester.
- A write back of the status word with bit 62 still set must not release the record. A design that released it would drop a fault that was never handled.
- A fault in the same cycle as the release is checked in both orders. One design would lose that fault; another would keep an acknowledged record alive.
- Saturation is driven past 255. A counter that wrapped would report a small count after a storm of faults.
- Writes of all ones probe the reserved control bits and the read-only overflow word.

// File: rtl/fault_rec_pkg.sv
package fault_rec_pkg;
  localparam int WORD_W    = 64;
  localparam int TYPE_W    = 3;
  localparam int RID_W     = 16;
  localparam int ADDR_W    = 32;
  localparam int PARAM_W   = 10;
  localparam int VALID_BIT = 63;
  localparam int PEND_BIT  = 62;
  localparam int TYPE_LSB  = 59;
  localparam int RID_LSB   = 37;
  localparam int EN_BIT    = 63;
  localparam int PARAM_LSB = 10;

  typedef enum logic [1:0] {
    IDX_STATUS = 2'd0,
    IDX_CTRL   = 2'd1,
    IDX_OVF    = 2'd2,
    IDX_NONE   = 2'd3
  } reg_idx_e;
endpackage

// File: rtl/fault_ctrl_reg.sv
module fault_ctrl_reg
  import fault_rec_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic [WORD_W-1:0] ctrl_o
);
  localparam logic [WORD_W-1:0] KEEP_MASK =
    (WORD_W'(1) << EN_BIT) | (((WORD_W'(1) << PARAM_W) - 1) << PARAM_LSB);

  logic [WORD_W-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q <= '0;
    else if (we_i) q <= wdata_i & KEEP_MASK;
  end

  assign ctrl_o = q;

  // R8: reserved control bits never hold a 1
  a_r8_reserved_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (q & ~KEEP_MASK) == '0);
endmodule

// File: rtl/fault_status_reg.sv
module fault_status_reg
  import fault_rec_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hit_i,
  input  logic [TYPE_W-1:0] type_i,
  input  logic [RID_W-1:0]  rid_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              ack_i,
  output logic [WORD_W-1:0] status_o
);
  logic [WORD_W-1:0] q, rec;
  logic              held, cap;

  assign held = q[VALID_BIT];
  assign cap  = hit_i && !held;

  always_comb begin
    rec = '0;
    rec[VALID_BIT] = 1'b1;
    rec[PEND_BIT]  = 1'b1;
    rec[TYPE_LSB +: TYPE_W] = type_i;
    rec[RID_LSB  +: RID_W]  = rid_i;
    rec[0 +: ADDR_W]        = addr_i;
  end

  // capture beats release when nothing is held
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= '0;
    else if (cap) q <= rec;
    else if (ack_i) begin
      q[VALID_BIT] <= 1'b0;
      q[PEND_BIT]  <= 1'b0;
    end
  end

  assign status_o = q;

  a_r2_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_i && !held |=> status_o[VALID_BIT] && status_o[PEND_BIT] &&
                       status_o[RID_LSB +: RID_W] == $past(rid_i));
  a_r4_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    held && !ack_i |=> $stable(status_o));
  a_r6_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    held && ack_i |=> !status_o[VALID_BIT] && !status_o[PEND_BIT]);
  a_r3_no_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !held && !hit_i |=> !status_o[VALID_BIT]);
endmodule

// File: rtl/fault_ovf_counter.sv
module fault_ovf_counter #(
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  output logic [WIDTH-1:0] count_o
);
  localparam logic [WIDTH-1:0] TOP = '1;

  logic [WIDTH-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 q <= '0;
    else if (inc_i && q != TOP)  q <= q + 1'b1;
  end

  assign count_o = q;

  a_r5_saturate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    q == TOP |=> q == TOP);
  a_r4_count_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc_i && q != TOP |=> q == $past(q) + 1'b1);
  a_r4_count_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !inc_i |=> $stable(q));
endmodule

// File: rtl/iommu_fault_recorder.sv
module iommu_fault_recorder
  import fault_rec_pkg::*;
#(
  parameter int OVF_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fault_valid_i,
  input  logic [2:0]        fault_type_i,
  input  logic [15:0]       fault_rid_i,
  input  logic [31:0]       fault_addr_i,
  input  logic              wr_en_i,
  input  logic [1:0]        reg_idx_i,
  input  logic [63:0]       wdata_i,
  output logic [63:0]       rdata_o,
  output logic              irq_o
);
  logic [WORD_W-1:0] status, ctrl;
  logic [OVF_W-1:0]  ovf_cnt;
  logic              enabled, hit, ack, ctrl_we;

  assign enabled = ctrl[EN_BIT];
  assign hit     = fault_valid_i && enabled;
  assign ctrl_we = wr_en_i && reg_idx_i == IDX_CTRL;
  assign ack     = wr_en_i && reg_idx_i == IDX_STATUS && !wdata_i[PEND_BIT];

  fault_ctrl_reg u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (ctrl_we),
    .wdata_i (wdata_i),
    .ctrl_o  (ctrl)
  );

  fault_status_reg u_status (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .hit_i    (hit),
    .type_i   (fault_type_i),
    .rid_i    (fault_rid_i),
    .addr_i   (fault_addr_i),
    .ack_i    (ack),
    .status_o (status)
  );

  fault_ovf_counter #(.WIDTH(OVF_W)) u_ovf (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .inc_i   (hit && status[VALID_BIT]),
    .count_o (ovf_cnt)
  );

  always_comb begin
    unique case (reg_idx_i)
      IDX_STATUS: rdata_o = status;
      IDX_CTRL:   rdata_o = ctrl;
      IDX_OVF:    rdata_o = WORD_W'(ovf_cnt);
      default:    rdata_o = '0;
    endcase
  end

  assign irq_o = status[VALID_BIT];

  // R3: disabled reporting never starts a record
  a_r3_disabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enabled && !irq_o |=> !irq_o);
  a_r10_irq_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o && !ack |=> irq_o);
endmodule

// File: tb/sim_iommu_fault_recorder.sv
`timescale 1ns/1ps
module sim_iommu_fault_recorder;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        fault_valid_i = 1'b0;
  logic [2:0]  fault_type_i = '0;
  logic [15:0] fault_rid_i = '0;
  logic [31:0] fault_addr_i = '0;
  logic        wr_en_i = 1'b0;
  logic [1:0]  reg_idx_i = '0;
  logic [63:0] wdata_i = '0;
  logic [63:0] rdata_o;
  logic        irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // behavioural reference state
  logic [63:0] m_status = '0;
  logic [63:0] m_ctrl = '0;
  int          m_ovf = 0;

  always #10 clk_i = ~clk_i;

  iommu_fault_recorder u0 (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .fault_valid_i(fault_valid_i), .fault_type_i(fault_type_i),
    .fault_rid_i(fault_rid_i), .fault_addr_i(fault_addr_i),
    .wr_en_i(wr_en_i), .reg_idx_i(reg_idx_i), .wdata_i(wdata_i),
    .rdata_o(rdata_o), .irq_o(irq_o)
  );

  function automatic logic [63:0] model_read(int idx);
    case (idx)
      0: return m_status;
      1: return m_ctrl;
      2: return 64'(m_ovf);
      default: return 64'h0;
    endcase
  endfunction

  task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic compare_all(string req);
    for (int a = 0; a < 4; a++) begin
      reg_idx_i = 2'(a);
      #1;
      check(req, $sformatf("word %0d", a), rdata_o, model_read(a));
    end
    check(req, "irq", 64'(irq_o), 64'(m_status[63]));
  endtask

  task automatic model_update(bit fv, logic [2:0] ty, logic [15:0] rid, logic [31:0] ad,
                              bit we, int idx, logic [63:0] wd);
    bit held = m_status[63];
    bit en   = m_ctrl[63];
    logic [63:0] rec;
    if (we && idx == 0 && !wd[62]) begin
      m_status[63] = 1'b0;
      m_status[62] = 1'b0;
    end
    if (fv && en) begin
      if (held) begin
        if (m_ovf < 255) m_ovf++;
      end else begin
        rec = '0;
        rec[63] = 1'b1; rec[62] = 1'b1;
        rec[61:59] = ty; rec[52:37] = rid; rec[31:0] = ad;
        m_status = rec;
      end
    end
    if (we && idx == 1) begin
      m_ctrl = '0;
      m_ctrl[63] = wd[63];
      m_ctrl[19:10] = wd[19:10];
    end
  endtask

  task automatic step(string req, bit fv, logic [2:0] ty, logic [15:0] rid, logic [31:0] ad,
                      bit we, int idx, logic [63:0] wd);
    fault_valid_i = fv; fault_type_i = ty; fault_rid_i = rid; fault_addr_i = ad;
    wr_en_i = we; reg_idx_i = 2'(idx); wdata_i = wd;
    @(posedge clk_i);
    model_update(fv, ty, rid, ad, we, idx, wd);
    #2;
    fault_valid_i = 1'b0; wr_en_i = 1'b0;
    compare_all(req);
  endtask

  task automatic fault(string req, logic [2:0] ty, logic [15:0] rid, logic [31:0] ad);
    step(req, 1'b1, ty, rid, ad, 1'b0, 0, 64'h0);
  endtask

  task automatic wr(string req, int idx, logic [63:0] wd);
    step(req, 1'b0, 3'd0, 16'h0, 32'h0, 1'b1, idx, wd);
  endtask

  initial begin
    repeat (3) @(posedge clk_i);
    #3;
    compare_all("R1");
    rst_ni = 1'b1;
    @(negedge clk_i);
    compare_all("R1");

    fault("R3", 3'd4, 16'h1234, 32'h0000_1000);
    wr("R8", 1, 64'hFFFF_FFFF_FFFF_FFFF);
    wr("R8", 1, (64'h1 << 63) | (64'h100 << 10));

    fault("R2", 3'd5, 16'hBEEF, 32'hDEAD_BEEF);
    fault("R4", 3'd1, 16'h0042, 32'h1111_2222);
    wr("R7", 0, 64'hFFFF_FFFF_FFFF_FFFF);
    wr("R11", 2, 64'hFFFF_FFFF_FFFF_FFFF);
    wr("R11", 3, 64'hFFFF_FFFF_FFFF_FFFF);
    wr("R6", 0, 64'hBFFF_FFFF_FFFF_FFFF);
    step("R6", 1'b0, 3'd0, 16'h0, 32'h0, 1'b0, 0, 64'h0);

    for (int t = 0; t < 6; t++) begin
      fault("R10", 3'(t), 16'(16'hA000 + t), 32'(32'h8000_0000 + t * 8192));
      wr("R6", 0, 64'h0);
    end

    fault("R2", 3'd3, 16'hFFFF, 32'hFFFF_FFFF);
    step("R9", 1'b1, 3'd2, 16'h0101, 32'h0202_0303, 1'b1, 0, 64'h0);
    step("R9", 1'b1, 3'd0, 16'h5A5A, 32'h0BAD_F00D, 1'b1, 0, 64'h0);

    for (int n = 0; n < 300; n++)
      fault("R5", 3'd4, 16'(n), 32'(n));

    wr("R6", 0, 64'h0);
    wr("R3", 1, 64'h0);
    fault("R3", 3'd5, 16'h7777, 32'h7777_7777);
    fault("R3", 3'd1, 16'h8888, 32'h8888_8888);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule